// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is a first-in first-out buffer, nine bits wide, with a write side and a read side on two unrelated clocks. Both sides may be active in the same moment. Each side has a pair of active-low enables. The write side reports full and almost-full. The read side reports empty and almost-empty. The read data sits in an output register that a separate active-low output enable can release to high impedance.

Two threshold values set the almost flags. Each threshold is split into a 9-bit low part and a high part that holds the remaining address bits. The four parts live in registers that are written and read back over the normal data path. The level of the second write enable during reset picks its role. Held high, it is a second write enable. Held low, it becomes a load strobe. Each strobed access then steps through the four threshold parts in a fixed cyclic order. Pointers cross between the clock domains in Gray code through two-flop synchronizers. The depth is a power-of-two parameter of at least 1024.

Top module: `dcf_fifo`

## Requirements
- R1: After reset: empty_no=0, full_no=1, aempty_no=0, afull_no=1, q_o=0. Both thresholds are 7, held as low part 7 and high part 0.
- R2: In normal mode a word is stored at a wclk_i rising edge only when wen1_ni and wen2_ld_ni are both 0. Either enable alone stores nothing.
- R3: A read happens at an rclk_i rising edge only when ren1_ni and ren2_ni are both 0. The oldest word is loaded into q_o at that edge, and words leave in write order.
- R4: full_no is 0 while DEPTH words are stored. A write attempted while full is dropped, and no stored word changes.
- R5: A read attempted while empty is dropped: q_o holds its value and no pointer moves.
- R6: empty_no is 0 while no word is stored. It goes to 1 within a few rclk_i edges of the first write.
- R7: afull_no is 0 when the free locations number at most the almost-full threshold m, and 1 when more than m are free.
- R8: aempty_no is 0 when the stored words number at most the almost-empty threshold n, and 1 when more than n are stored.
- R9: wen2_ld_ni is sampled while rst_ni is low and up to the first wclk_i edge after release. A 1 selects normal mode. A 0 selects load mode.
- R10: In load mode, a write with wen1_ni=0 and wen2_ld_ni=0 goes to a threshold register and not to the buffer. The order is position 0 = almost-empty low, 1 = almost-empty high, 2 = almost-full low, 3 = almost-full high, then back to 0. A high part keeps only bits [AW-10:0] of wdata_i.
- R11: In load mode, a read with ren1_ni=0, ren2_ni=0 and wen2_ld_ni=0 places the threshold part at the read-side position on q_o, with high parts zero-extended. It then steps through the same cyclic order and leaves the buffer untouched.
- R12: In load mode, a buffer write needs wen1_ni=0 with wen2_ld_ni=1. A buffer read needs both read enables low with wen2_ld_ni=1.
- R13: With oe_ni=0, q_o drives the output register. With oe_ni=1, q_o is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen1_ni | input | 1 | Write enable 1, active low |
| wen2_ld_ni | input | 1 | Write enable 2 or load strobe, role fixed at reset |
| wdata_i | input | 9 | Write data / threshold load data |
| full_no | output | 1 | Full flag, active low, write domain |
| afull_no | output | 1 | Almost-full flag, active low, write domain |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| oe_ni | input | 1 | Output enable for q_o, active low |
| q_o | output | 9 | Read data, high impedance when oe_ni=1 |
| empty_no | output | 1 | Empty flag, active low, read domain |
| aempty_no | output | 1 | Almost-empty flag, active low, read domain |

## Verification
A long ordered stream of distinct words fills the buffer to its last location. This separates a correct full boundary and a dropped overflow from an off-by-one depth, and a full readback shows any word that was lost or reordered. Writes and reads with only one enable low show whether both enables are required. Short fills stepped one word past each threshold tell a less-than from a less-or-equal comparison, both for the reset thresholds and for loaded ones. The load-mode run writes five threshold values and reads back nine. It covers the order, the truncation of the high part, the wrap on both sides, and the fact that threshold traffic never adds or removes buffer words.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DW   = 9;
  localparam int unsigned LO_W = 9;
  localparam logic [LO_W-1:0] OFS_LO_RST = LO_W'(7);

  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  // gray to binary: bit i is xor of all bits at or above i
  always_comb begin
    for (int i = 0; i < int'(W); i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 9,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned HI_W = AW - LO_W
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_ld_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW:0]   rbin_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   wgray_o,
  output logic          ld_mode_o,
  output logic [1:0]    wseq_o,
  output logic [AW-1:0] ae_ofs_o,
  output logic [AW-1:0] af_ofs_o,
  output logic          full_no,
  output logic          afull_no
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [AW:0]     wptr_q, wgray_q, wnext, wcount, free;
  logic [LO_W-1:0] ae_lo_q, af_lo_q;
  logic [HI_W-1:0] ae_hi_q, af_hi_q;
  logic [1:0]      wseq_q;
  logic            rst_q, ld_mode_q, fifo_wr, ofs_wr, full;

  // rst_q stays low until the first clock after release; mode is sampled until then
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= 1'b1;
  end

  always_ff @(posedge wclk_i) begin
    if (!rst_q) ld_mode_q <= ~wen2_ld_ni;
  end

  assign wcount  = wptr_q - rbin_i;
  assign full    = (wcount == DEPTH_W);
  assign free    = DEPTH_W - wcount;
  assign wnext   = wptr_q + 1'b1;
  assign fifo_wr = ~wen1_ni & (ld_mode_q ? wen2_ld_ni : ~wen2_ld_ni);
  assign ofs_wr  = ld_mode_q & ~wen1_ni & ~wen2_ld_ni;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      wseq_q  <= 2'd0;
      ae_lo_q <= OFS_LO_RST;
      ae_hi_q <= '0;
      af_lo_q <= OFS_LO_RST;
      af_hi_q <= '0;
    end else begin
      if (fifo_wr && !full) begin
        wptr_q  <= wnext;
        wgray_q <= wnext ^ (wnext >> 1);
      end
      if (ofs_wr) begin
        unique case (ofs_sel_e'(wseq_q))
          SEL_AE_LO: ae_lo_q <= wdata_i;
          SEL_AE_HI: ae_hi_q <= wdata_i[HI_W-1:0];
          SEL_AF_LO: af_lo_q <= wdata_i;
          SEL_AF_HI: af_hi_q <= wdata_i[HI_W-1:0];
          default: ;
        endcase
        wseq_q <= wseq_q + 2'd1;
      end
    end
  end

  assign we_o      = fifo_wr & ~full;
  assign waddr_o   = wptr_q[AW-1:0];
  assign wptr_o    = wptr_q;
  assign wgray_o   = wgray_q;
  assign ld_mode_o = ld_mode_q;
  assign wseq_o    = wseq_q;
  assign ae_ofs_o  = {ae_hi_q, ae_lo_q};
  assign af_ofs_o  = {af_hi_q, af_lo_q};
  assign full_no   = ~full;
  assign afull_no  = (free > {1'b0, af_hi_q, af_lo_q});
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic          ld_req_i,
  input  logic [AW:0]   wbin_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_o,
  output logic [AW:0]   rgray_o,
  output logic [1:0]    rseq_o,
  output logic [DW-1:0] q_o,
  output logic          empty_no,
  output logic          aempty_no
);
  logic [AW:0]     rptr_q, rgray_q, rnext, rcount;
  logic [1:0]      rseq_q;
  logic [DW-1:0]   q_q, ofs_word;
  logic            ren, ofs_rd, fifo_rd, empty;

  assign rcount  = wbin_i - rptr_q;
  assign empty   = (rcount == '0);
  assign rnext   = rptr_q + 1'b1;
  assign ren     = ~ren1_ni & ~ren2_ni;
  assign ofs_rd  = ren & ld_req_i;
  assign fifo_rd = ren & ~ld_req_i & ~empty;

  always_comb begin
    unique case (ofs_sel_e'(rseq_q))
      SEL_AE_LO: ofs_word = ae_ofs_i[LO_W-1:0];
      SEL_AE_HI: ofs_word = DW'(ae_ofs_i[AW-1:LO_W]);
      SEL_AF_LO: ofs_word = af_ofs_i[LO_W-1:0];
      default:   ofs_word = DW'(af_ofs_i[AW-1:LO_W]);
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      rseq_q  <= 2'd0;
      q_q     <= '0;
    end else if (ofs_rd) begin
      q_q    <= ofs_word;
      rseq_q <= rseq_q + 2'd1;
    end else if (fifo_rd) begin
      q_q     <= mem_rdata_i;
      rptr_q  <= rnext;
      rgray_q <= rnext ^ (rnext >> 1);
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rptr_o    = rptr_q;
  assign rgray_o   = rgray_q;
  assign rseq_o    = rseq_q;
  assign q_o       = q_q;
  assign empty_no  = ~empty;
  assign aempty_no = (rcount > {1'b0, ae_ofs_i});
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_ld_ni,
  input  logic [DW-1:0] wdata_i,
  output logic          full_no,
  output logic          afull_no,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] q_o,
  output logic          empty_no,
  output logic          aempty_no
);
  logic          we, ld_mode, ld_req;
  logic [AW-1:0] waddr, raddr, ae_ofs, af_ofs;
  logic [AW:0]   wptr_bin, wgray, rptr_bin, rgray, wbin_s, rbin_s;
  logic [1:0]    wseq, rseq;
  logic [DW-1:0] mem_rdata, q_reg;

  assign ld_req = ld_mode & ~wen2_ld_ni;

  dcf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .wclk_i (wclk_i), .we_i (we), .waddr_i (waddr), .wdata_i (wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  dcf_sync #(.W(AW+1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_s)
  );

  dcf_sync #(.W(AW+1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_s)
  );

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .wen1_ni   (wen1_ni),
    .wen2_ld_ni(wen2_ld_ni),
    .wdata_i   (wdata_i),
    .rbin_i    (rbin_s),
    .we_o      (we),
    .waddr_o   (waddr),
    .wptr_o    (wptr_bin),
    .wgray_o   (wgray),
    .ld_mode_o (ld_mode),
    .wseq_o    (wseq),
    .ae_ofs_o  (ae_ofs),
    .af_ofs_o  (af_ofs),
    .full_no   (full_no),
    .afull_no  (afull_no)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rclk_i     (rclk_i),
    .rst_ni     (rst_ni),
    .ren1_ni    (ren1_ni),
    .ren2_ni    (ren2_ni),
    .ld_req_i   (ld_req),
    .wbin_i     (wbin_s),
    .ae_ofs_i   (ae_ofs),
    .af_ofs_i   (af_ofs),
    .mem_rdata_i(mem_rdata),
    .raddr_o    (raddr),
    .rptr_o     (rptr_bin),
    .rgray_o    (rgray),
    .rseq_o     (rseq),
    .q_o        (q_reg),
    .empty_no   (empty_no),
    .aempty_no  (aempty_no)
  );

  assign q_o = oe_ni ? 'z : q_reg;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wen1_ni,
  input logic        wen2_ld_ni,
  input logic        ren1_ni,
  input logic        ren2_ni,
  input logic        full_no,
  input logic        afull_no,
  input logic        empty_no,
  input logic        aempty_no,
  input logic        ld_mode,
  input logic        ld_req,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr,
  input logic [1:0]  wseq,
  input logic [1:0]  rseq
);
  p_no_overflow_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!full_no && !wen1_ni && (ld_mode ? wen2_ld_ni : !wen2_ld_ni)) |=> $stable(wptr));

  p_no_underflow_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && !ren1_ni && !ren2_ni && !ld_req) |=> $stable(rptr));

  p_wptr_step_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    1'b1 |=> (wptr == $past(wptr) || wptr == $past(wptr) + 1'b1));

  p_full_afull_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);

  p_empty_aempty_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);

  p_wseq_step_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ld_mode && !wen1_ni && !wen2_ld_ni) |=> (wseq == $past(wseq) + 2'd1));

  p_rseq_step_r11: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ld_req && !ren1_ni && !ren2_ni) |=> (rseq == $past(rseq) + 2'd1 && $stable(rptr)));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .wen1_ni   (wen1_ni),
  .wen2_ld_ni(wen2_ld_ni),
  .ren1_ni   (ren1_ni),
  .ren2_ni   (ren2_ni),
  .full_no   (full_no),
  .afull_no  (afull_no),
  .empty_no  (empty_no),
  .aempty_no (aempty_no),
  .ld_mode   (ld_mode),
  .ld_req    (ld_req),
  .wptr      (wptr_bin),
  .rptr      (rptr_bin),
  .wseq      (wseq),
  .rseq      (rseq)
);

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
  localparam int DEPTH = 1024;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wen1 = 1'b1, wen2 = 1'b1, ren1 = 1'b1, ren2 = 1'b1, oe_n = 1'b0;
  logic [8:0] wdata = '0;
  logic [8:0] q;
  logic       full_n, afull_n, empty_n, aempty_n;
  bit         ld_m = 1'b0;
  bit         done = 1'b0;
  int         n_chk = 0, n_err = 0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcf_fifo #(.DEPTH(DEPTH)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wen1_ni(wen1), .wen2_ld_ni(wen2), .wdata_i(wdata),
    .full_no(full_n), .afull_no(afull_n),
    .ren1_ni(ren1), .ren2_ni(ren2), .oe_ni(oe_n), .q_o(q),
    .empty_no(empty_n), .aempty_no(aempty_n)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) & 'h1FF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit ld);
    ld_m  = ld;
    rst_n = 1'b0;
    wen1 = 1'b1; ren1 = 1'b1; ren2 = 1'b1; oe_n = 1'b0;
    wen2 = ld ? 1'b0 : 1'b1;
    repeat (4) @(negedge wclk);
    rst_n = 1'b1;
    repeat (2) @(negedge wclk);
    wen2 = 1'b1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr_raw(input logic w1, input logic w2, input logic [8:0] d);
    @(negedge wclk);
    wdata = d; wen1 = w1; wen2 = w2;
    @(negedge wclk);
    wen1 = 1'b1; wen2 = 1'b1;
  endtask

  task automatic wr_fifo(input logic [8:0] d);
    wr_raw(1'b0, ld_m ? 1'b1 : 1'b0, d);
  endtask

  task automatic rd_raw(input logic r1, input logic r2, input logic w2, output logic [8:0] d);
    @(negedge rclk);
    ren1 = r1; ren2 = r2; wen2 = w2;
    @(negedge rclk);
    ren1 = 1'b1; ren2 = 1'b1; wen2 = 1'b1;
    d = q;
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset(1'b0);
    chk(empty_n == 1'b0,  "R1 empty_no", empty_n, 0);
    chk(full_n == 1'b1,   "R1 full_no", full_n, 1);
    chk(aempty_n == 1'b0, "R1 aempty_no", aempty_n, 0);
    chk(afull_n == 1'b1,  "R1 afull_no", afull_n, 1);
    chk(q == 9'h000,      "R1 q_o", q, 0);
  endtask

  // R2, R3, R5, R6: enable pairs and ordering
  task automatic t_enables();
    logic [8:0] d;
    do_reset(1'b0);
    wr_raw(1'b0, 1'b1, 9'h011);
    wr_raw(1'b1, 1'b0, 9'h022);
    settle();
    chk(empty_n == 1'b0, "R2 single enable stored nothing", empty_n, 0);
    rd_raw(1'b0, 1'b0, 1'b1, d);
    chk(d == 9'h000, "R5 read while empty holds q", d, 0);
    for (int i = 0; i < 3; i++) wr_fifo(pat(i));
    settle();
    chk(empty_n == 1'b1, "R6 empty_no after writes", empty_n, 1);
    rd_raw(1'b0, 1'b1, 1'b1, d);
    chk(d == 9'h000, "R3 ren1 alone no read", d, 0);
    rd_raw(1'b1, 1'b0, 1'b1, d);
    chk(d == 9'h000, "R3 ren2 alone no read", d, 0);
    for (int i = 0; i < 3; i++) begin
      rd_raw(1'b0, 1'b0, 1'b1, d);
      chk(d == pat(i), "R3 read order", d, pat(i));
    end
    settle();
    chk(empty_n == 1'b0, "R6 empty_no after drain", empty_n, 0);
    rd_raw(1'b0, 1'b0, 1'b1, d);
    chk(d == pat(2), "R5 read while empty holds q", d, pat(2));
  endtask

  // R8: default almost-empty threshold 7
  task automatic t_aempty();
    do_reset(1'b0);
    for (int i = 0; i < 7; i++) wr_fifo(pat(i));
    settle();
    chk(aempty_n == 1'b0, "R8 7 words aempty_no", aempty_n, 0);
    wr_fifo(pat(7));
    settle();
    chk(aempty_n == 1'b1, "R8 8 words aempty_no", aempty_n, 1);
  endtask

  // R4, R7: fill to the end, overflow dropped
  task automatic t_full();
    logic [8:0] d;
    do_reset(1'b0);
    for (int i = 0; i < DEPTH - 8; i++) wr_fifo(pat(i));
    chk(afull_n == 1'b1, "R7 8 free afull_no", afull_n, 1);
    wr_fifo(pat(DEPTH - 8));
    chk(afull_n == 1'b0, "R7 7 free afull_no", afull_n, 0);
    chk(full_n == 1'b1, "R4 not yet full", full_n, 1);
    for (int i = DEPTH - 7; i < DEPTH; i++) wr_fifo(pat(i));
    chk(full_n == 1'b0, "R4 full_no at DEPTH", full_n, 0);
    wr_fifo(9'h1AA);
    chk(full_n == 1'b0, "R4 still full after overflow", full_n, 0);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd_raw(1'b0, 1'b0, 1'b1, d);
      if (d != pat(i)) chk(1'b0, "R4 readback after overflow", d, pat(i));
    end
    chk(1'b1, "R4 readback", 0, 0);
    settle();
    chk(empty_n == 1'b0, "R4 overflow word not stored", empty_n, 0);
    chk(full_n == 1'b1, "R4 full_no cleared", full_n, 1);
  endtask

  // R13: output enable
  task automatic t_oe();
    logic [8:0] d;
    do_reset(1'b0);
    wr_fifo(9'h155);
    settle();
    rd_raw(1'b0, 1'b0, 1'b1, d);
    chk(d == 9'h155, "R13 driven with oe_ni=0", d, 9'h155);
    oe_n = 1'b1;
    #1;
    chk(q !== 9'h155, "R13 released with oe_ni=1", q, 9'h155);
    oe_n = 1'b0;
    #1;
    chk(q == 9'h155, "R13 driven again", q, 9'h155);
  endtask

  // R9, R10, R11, R12: load mode
  task automatic t_load();
    logic [8:0] d;
    logic [8:0] exp_dflt [4] = '{9'h007, 9'h000, 9'h007, 9'h000};
    logic [8:0] exp_ld [4]   = '{9'h003, 9'h000, 9'h002, 9'h001};
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) begin
      rd_raw(1'b0, 1'b0, 1'b0, d);
      chk(d == exp_dflt[i], "R11 default readback", d, exp_dflt[i]);
    end
    wr_raw(1'b0, 1'b0, 9'h003);
    wr_raw(1'b0, 1'b0, 9'h000);
    wr_raw(1'b0, 1'b0, 9'h002);
    wr_raw(1'b0, 1'b0, 9'h1FF);
    settle();
    chk(empty_n == 1'b0, "R9 load strobe wrote no word", empty_n, 0);
    for (int i = 0; i < 4; i++) begin
      rd_raw(1'b0, 1'b0, 1'b0, d);
      chk(d == exp_ld[i], "R10 R11 loaded readback", d, exp_ld[i]);
    end
    rd_raw(1'b0, 1'b0, 1'b0, d);
    chk(d == 9'h003, "R11 read position wraps", d, 9'h003);
    wr_raw(1'b0, 1'b0, 9'h004);
    for (int i = 1; i < 4; i++) rd_raw(1'b0, 1'b0, 1'b0, d);
    rd_raw(1'b0, 1'b0, 1'b0, d);
    chk(d == 9'h004, "R10 write position wraps", d, 9'h004);
    for (int i = 0; i < 4; i++) wr_fifo(pat(100 + i));
    settle();
    chk(empty_n == 1'b1, "R12 load-mode buffer write", empty_n, 1);
    chk(aempty_n == 1'b0, "R8 4 words at n=4", aempty_n, 0);
    wr_fifo(pat(104));
    settle();
    chk(aempty_n == 1'b1, "R8 5 words above n=4", aempty_n, 1);
    rd_raw(1'b0, 1'b0, 1'b1, d);
    chk(d == pat(100), "R12 load-mode buffer read", d, pat(100));
    settle();
    // 4 words stored, m = 512 + 2 = 514
    for (int i = 4; i < 509; i++) wr_fifo(pat(i));
    chk(afull_n == 1'b1, "R7 515 free at m=514", afull_n, 1);
    wr_fifo(pat(509));
    chk(afull_n == 1'b0, "R7 514 free at m=514", afull_n, 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enables();
    t_aempty();
    t_full();
    t_oe();
    t_load();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule